// File: doc/BRIEF.md
# Start/Done Handshake Controller for a Fixed-Latency Datapath

This block puts a small control state machine in front of a compute datapath whose latency is fixed. An upstream agent raises `startReq` while `readyOut` is high. In that cycle the block takes both operands into registers and begins a run that lasts `LATENCY` compute cycles. During each compute cycle the datapath adds the captured second operand to an accumulator, which was seeded with the first operand. When the run ends, `doneOut` is raised and `resultOut` holds `opA + LATENCY*opB`, truncated to `DATA_W` bits.

The parameter `CHAIN_MODE` selects one of two completion behaviours. In chain mode, which is the default, completion is held. `doneOut` stays high and no new work is taken until a downstream consumer raises `contIn`, so the consumer can exert back pressure. In plain mode `contIn` is ignored, `doneOut` is a single-cycle pulse, and the block returns to idle on its own. `idleOut` is high only when no run is active and no completion is pending. The reset is synchronous and active high.

Top module: `run_handshake_top`

## Requirements
- R1: After a synchronous reset, `idleOut` = 1, `readyOut` = 1 and `doneOut` = 0.
- R2: A start is accepted at a rising edge where `startReq` = 1 and `readyOut` = 1. At that edge `opA` and `opB` are captured. From the next cycle on, `readyOut` and `idleOut` are 0.
- R3: While `readyOut` = 0, `startReq` and any operand changes have no effect on the result being computed or on its timing.
- R4: `doneOut` rises exactly `LATENCY` clock edges after the accepting edge. At that point `resultOut` = (`opA` + `LATENCY`*`opB`) mod 2^`DATA_W`, computed from the captured operands.
- R5: In plain mode (`CHAIN_MODE` = 0), `doneOut` is high for exactly one cycle. In the following cycle `idleOut` = 1 and `readyOut` = 1.
- R6: In chain mode (`CHAIN_MODE` = 1), `doneOut` stays high until an edge where `contIn` = 1. After that edge `doneOut` = 0 and `idleOut` = `readyOut` = 1.
- R7: In chain mode, `readyOut` = 0 while `doneOut` = 1, so a start raised during a pending completion is not accepted.
- R8: `contIn` has no effect while a run is in progress, and it has no effect at any time in plain mode.
- R9: `idleOut` and `doneOut` are never high together.
- R10: `resultOut` stays stable from the rise of `doneOut` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to launch one run |
| contIn | input | 1 | Downstream release of a pending completion (chain mode only) |
| opA | input | DATA_W | Seed operand, captured on accept |
| opB | input | DATA_W | Step operand, captured on accept |
| idleOut | output | 1 | No run active and no completion pending |
| doneOut | output | 1 | Run has completed |
| readyOut | output | 1 | Block can accept a start this cycle |
| resultOut | output | DATA_W | Computed result |

## Verification
The bench uses a 4-bit, 3-cycle configuration and sweeps every pair of operands through both a chain-mode and a plain-mode instance. A wrong seed, a wrong step count or a wrong step operand each produces a different arithmetic error. During every run the bench raises `startReq` and `contIn` and drives unrelated operand values. A block that recaptures operands or reacts to an early release then gives a wrong result or a wrong done timing. The chain instance holds its completion for a release delay that varies from zero to three cycles, with a start request present the whole time. This separates a true hold from a fixed pulse and shows whether starts are ignored during the hold.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} hsState_e;

  typedef struct packed {
    logic load;
    logic step;
  } dpStrobe_t;
endpackage

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int LATENCY    = 4,
  parameter bit CHAIN_MODE = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      startReq,
  input  logic      contIn,
  output dpStrobe_t strobes,
  output logic      idleOut,
  output logic      doneOut,
  output logic      readyOut
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LATENCY - 1);

  hsState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ;
  logic finExit;
  logic accept;

  // the mode decides what releases the completion state
  generate
    if (CHAIN_MODE) begin : g_chain
      assign finExit = contIn;
    end else begin : g_plain
      assign finExit = 1'b1;
    end
  endgenerate

  assign readyOut = (stateQ == ST_IDLE);
  assign idleOut  = (stateQ == ST_IDLE);
  assign doneOut  = (stateQ == ST_FIN);
  assign accept   = readyOut && startReq;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (accept) stateD = ST_RUN;
      ST_RUN:  if (cntQ == LAST_CNT) stateD = ST_FIN;
      ST_FIN:  if (finExit) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_RUN) cntQ <= cntQ + 1'b1;
      else                  cntQ <= '0;
    end
  end

  assign strobes.load = accept;
  assign strobes.step = (stateQ == ST_RUN);

  // R2: acceptance leaves the ready/idle state at once
  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    startReq && readyOut |=> !readyOut && !idleOut);

  // R4: the run counter never passes the configured latency
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_RUN) |-> (cntQ < CNT_W'(LATENCY)));

  generate
    if (CHAIN_MODE) begin : g_chainChk
      // R6: completion holds without a release
      a_r6_hold_until_cont: assert property (@(posedge clk) disable iff (rst)
        doneOut && !contIn |=> doneOut);
      // R6: a release returns the block to idle
      a_r6_release_to_idle: assert property (@(posedge clk) disable iff (rst)
        doneOut && contIn |=> idleOut && readyOut);
    end else begin : g_plainChk
      // R5: single-cycle done pulse
      a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        doneOut |=> !doneOut && idleOut);
    end
  endgenerate
endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resultOut
);
  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] stepQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ  <= '0;
      stepQ <= '0;
    end else if (strobes.load) begin
      accQ  <= opA;
      stepQ <= opB;
    end else if (strobes.step) begin
      accQ  <= accQ + stepQ;
    end
  end

  assign resultOut = accQ;

  // R2: a load strobe seeds the accumulator with the presented operand
  a_r2_seed_capture: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> accQ == $past(opA));

  // R10: without strobes the result does not move
  a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.load && !strobes.step |=> $stable(accQ));
endmodule

// File: rtl/run_handshake_top.sv
module run_handshake_top
  import hs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LATENCY    = 4,
  parameter bit CHAIN_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic              contIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              idleOut,
  output logic              doneOut,
  output logic              readyOut,
  output logic [DATA_W-1:0] resultOut
);
  dpStrobe_t strobes;

  hs_ctrl #(.LATENCY(LATENCY), .CHAIN_MODE(CHAIN_MODE)) u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .contIn(contIn),
    .strobes(strobes), .idleOut(idleOut), .doneOut(doneOut),
    .readyOut(readyOut)
  );

  hs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .opA(opA), .opB(opB),
    .resultOut(resultOut)
  );

  // R9: idle and done are exclusive
  a_r9_idle_not_done: assert property (@(posedge clk) disable iff (rst)
    !(idleOut && doneOut));

  // R10: result holds while a completion is shown
  a_r10_stable_on_done: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> $stable(resultOut));
endmodule

// File: tb/run_handshake_top_tb.sv
module run_handshake_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startC = 0, contC = 0, startP = 0, contP = 0;
  logic [DW-1:0] aC = '0, bC = '0, aP = '0, bP = '0;
  logic idleC, doneC, readyC, idleP, doneP, readyP;
  logic [DW-1:0] resC, resP;

  int testCnt = 0;
  int failCnt = 0;
  int cycles  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  run_handshake_top #(.DATA_W(DW), .LATENCY(LAT), .CHAIN_MODE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .startReq(startC), .contIn(contC), .opA(aC), .opB(bC),
    .idleOut(idleC), .doneOut(doneC), .readyOut(readyC), .resultOut(resC));

  run_handshake_top #(.DATA_W(DW), .LATENCY(LAT), .CHAIN_MODE(1'b0)) u_dutPlain (
    .clk(clk), .rst(rst), .startReq(startP), .contIn(contP), .opA(aP), .opB(bP),
    .idleOut(idleP), .doneOut(doneP), .readyOut(readyP), .resultOut(resP));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runChain(input int a, input int b, input int holdCyc);
    int exp;
    exp = (a + LAT * b) % (1 << DW);
    check(readyC === 1'b1, "R2 ready before start", int'(readyC), 1);
    startC = 1; aC = DW'(a); bC = DW'(b);
    tick();
    check(readyC === 1'b0 && idleC === 1'b0, "R2 busy after accept",
          int'({readyC, idleC}), 0);
    // R3/R8: noise during the run
    startC = 1; contC = 1; aC = DW'(a + 5); bC = DW'(b + 7);
    for (int i = 1; i < LAT; i++) begin
      tick();
      check(doneC === 1'b0, "R4 no early done", int'(doneC), 0);
    end
    tick();
    check(doneC === 1'b1, "R4 done at latency", int'(doneC), 1);
    check(int'(resC) == exp, "R4 chain result", int'(resC), exp);
    check(idleC === 1'b0, "R9 idle low with done", int'(idleC), 0);
    contC = 0;
    for (int i = 0; i < holdCyc; i++) begin
      check(readyC === 1'b0, "R7 ready low while pending", int'(readyC), 0);
      tick();
      check(doneC === 1'b1, "R6 done held", int'(doneC), 1);
      check(int'(resC) == exp, "R10 result stable", int'(resC), exp);
    end
    startC = 0; contC = 1;
    tick();
    contC = 0;
    check(doneC === 1'b0 && idleC === 1'b1 && readyC === 1'b1, "R6 released to idle",
          int'({doneC, idleC, readyC}), 3);
    check(int'(resC) == exp, "R10 result after release", int'(resC), exp);
  endtask

  task automatic runPlain(input int a, input int b);
    int exp;
    exp = (a + LAT * b) % (1 << DW);
    startP = 1; aP = DW'(a); bP = DW'(b);
    tick();
    check(readyP === 1'b0, "R2 plain busy", int'(readyP), 0);
    aP = DW'(a + 3); bP = DW'(b + 9); contP = 1;
    for (int i = 1; i < LAT; i++) tick();
    contP = 0;
    tick();
    check(doneP === 1'b1, "R5 plain done", int'(doneP), 1);
    check(int'(resP) == exp, "R4 plain result", int'(resP), exp);
    startP = 0;
    tick();
    check(doneP === 1'b0 && idleP === 1'b1 && readyP === 1'b1, "R5 R8 plain back to idle",
          int'({doneP, idleP, readyP}), 3);
    check(int'(resP) == exp, "R10 plain result held", int'(resP), exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    rst = 1;
    tick(); tick();
    rst = 0;
    check(idleC === 1'b1 && readyC === 1'b1 && doneC === 1'b0, "R1 chain reset",
          int'({idleC, readyC, doneC}), 6);
    check(idleP === 1'b1 && readyP === 1'b1 && doneP === 1'b0, "R1 plain reset",
          int'({idleP, readyP, doneP}), 6);
    for (int a = 0; a < (1 << DW); a++) begin
      for (int b = 0; b < (1 << DW); b++) begin
        runChain(a, b, (a + b) % 4);
        runPlain(a, b);
      end
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule